// File: doc/BRIEF.md
# Accumulator Store Rounding Unit

This block turns a 40-bit signed fixed-point accumulator into the 16-bit 1.15 fractional word that a store writes to memory. The result is the upper word of the accumulator, bits 31:16. The lower word, bits 15:0, is used only to decide whether that upper word is incremented. The instruction can ask for plain truncation or for rounding. Writebacks of the multiply-accumulate class are always rounded.

Two rounding styles are available. Conventional rounding rounds half up. Convergent rounding rounds an exact half to the even neighbour. Along with the rounded word, the unit passes on two signals for a later saturation stage: a flag raised when the round increment wraps the largest positive word into the most negative one, and the accumulator's sign bit.

The rounding logic itself is combinational. A parameter adds one register stage at the output, and that stage is on by default.

Top module: `acc_store_rounder`

## Requirements
- R1: When neither `round_req_i` nor `mac_wb_i` is 1, `word_o` equals accumulator bits 31:16 unchanged and bits 15:0 have no effect (truncation).
- R2: With rounding active and `conv_mode_i` = 0 (round half up), `word_o` is bits 31:16 plus 1 when the low word is in 0x8000..0xFFFF, and bits 31:16 unchanged when it is in 0x0000..0x7FFF.
- R3: With rounding active and `conv_mode_i` = 1 (round half to even), every low word other than exactly 0x8000 gives the same result as R2.
- R4: With rounding active, `conv_mode_i` = 1 and a low word of exactly 0x8000, the upper word increments only if accumulator bit 16 is 1. If bit 16 is 0, the upper word is unchanged.
- R5: `mac_wb_i` = 1 forces rounding whatever the value of `round_req_i`.
- R6: `ovf_o` is 1 exactly when the round increment takes an upper word of 0x7FFF to 0x8000. In that case `word_o` is 0x8000. In every other case `ovf_o` is 0, and an upper word of 0xFFFF wraps to 0x0000 without setting the flag.
- R7: `sign_o` equals accumulator bit 39 of the same operation.
- R8: With the output register present, the outputs for an operation appear one clock after `in_valid_i` is sampled, and `out_valid_o` is 1 only in that cycle. A synchronous active-low reset clears `out_valid_o`, `word_o`, `ovf_o` and `sign_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Accumulator operand is present |
| acc_i | input | 40 | Accumulator value to store |
| round_req_i | input | 1 | Instruction asks for rounding |
| mac_wb_i | input | 1 | Multiply-accumulate writeback; always rounded |
| conv_mode_i | input | 1 | 0 = round half up, 1 = round half to even |
| out_valid_o | output | 1 | Result is valid |
| word_o | output | 16 | Truncated or rounded 1.15 word |
| ovf_o | output | 1 | Round increment wrapped 0x7FFF to 0x8000 |
| sign_o | output | 1 | Accumulator sign bit for saturation |

## Verification
Two functions can act in the same cycle: a tie decision under round-half-to-even, and the signed wrap of the round adder. The bench provokes them together with an upper word of 0x7FFF and a low word of exactly 0x8000, once with bit 16 set and once with it clear. Bit 16 is part of the upper word, so 0x7FFF always has it set. The set case must increment, wrap to 0x8000 and raise `ovf_o`. The clear case uses an upper word of 0x7FFE and must leave both the word and the flag untouched. Each popped result is judged against a model built only from the requirements, comparing word, flag and sign together.

// File: rtl/acc_rnd_pkg.sv
// Package: shared definitions for the accumulator store rounding unit.
// Assumes: the accumulator is laid out as sign/guard bits, an upper word
// and a lower word, with the upper word taken as the stored 1.15 value.
package acc_rnd_pkg;

    // Rounding style selected by the mode input.
    typedef enum logic {
        RND_HALF_UP   = 1'b0,
        RND_HALF_EVEN = 1'b1
    } rnd_mode_e;

    // Result bundle carried from the rounding core to the output stage.
    typedef struct packed {
        logic [15:0] word;
        logic        ovf;
        logic        sign;
    } rnd_result_t;

endpackage

// File: rtl/acc_rnd_decide.sv
// Module: acc_rnd_decide
// Decides whether the upper accumulator word must be incremented.
// Assumes: lo_word_i is the discarded lower word and up_lsb_i is the
// least significant bit of the upper word. Purely combinational.
module acc_rnd_decide
    import acc_rnd_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] lo_word_i,
    input  logic              up_lsb_i,
    input  logic              round_en_i,
    input  rnd_mode_e         mode_i,
    output logic              inc_o
);

    localparam logic [WORD_W-1:0] HALF = {1'b1, {(WORD_W-1){1'b0}}};

    logic at_or_above_half;
    logic exact_half;

    assign at_or_above_half = lo_word_i[WORD_W-1];
    assign exact_half       = (lo_word_i == HALF);

    // Purpose: pick the increment for the selected rounding style.
    always_comb begin
        inc_o = 1'b0;
        if (round_en_i) begin
            if (mode_i == RND_HALF_EVEN && exact_half) begin
                inc_o = up_lsb_i;
            end else begin
                inc_o = at_or_above_half;
            end
        end
    end

    // Purpose: an increment never occurs for a low word below one half (R2, R3).
    always_comb begin
        if (inc_o) begin
            p_inc_needs_half_r2: assert (lo_word_i[WORD_W-1] && round_en_i)
                else $error("increment without half or without rounding");
        end
    end

endmodule

// File: rtl/acc_rnd_adder.sv
// Module: acc_rnd_adder
// Adds the round increment to the upper word and flags a signed wrap.
// Assumes: inc_i is 0 or 1. The flag covers only the positive-to-negative
// wrap, because an increment can never leave the range the other way.
module acc_rnd_adder #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] up_i,
    input  logic              inc_i,
    output logic [WORD_W-1:0] sum_o,
    output logic              ovf_o
);

    localparam logic [WORD_W-1:0] MAX_POS = {1'b0, {(WORD_W-1){1'b1}}};

    // Purpose: form the rounded word and the signed overflow flag.
    always_comb begin
        sum_o = up_i + {{(WORD_W-1){1'b0}}, inc_i};
        ovf_o = inc_i && (up_i == MAX_POS);
    end

    // Purpose: an overflow always turns a positive word negative (R6).
    always_comb begin
        if (ovf_o) begin
            p_ovf_wrap_r6: assert (sum_o[WORD_W-1] && !up_i[WORD_W-1])
                else $error("overflow flag without sign wrap");
        end
    end

endmodule

// File: rtl/acc_store_rounder.sv
// Module: acc_store_rounder (top)
// Converts an accumulator into a truncated or rounded 1.15 store word.
// Assumes: ACC_W >= 2*WORD_W + 1. Bits above the upper word other than the
// sign are guard bits that this stage does not use. OUT_REG selects a
// registered (1) or purely combinational (0) output.
module acc_store_rounder
    import acc_rnd_pkg::*;
#(
    parameter int ACC_W   = 40,
    parameter int WORD_W  = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [ACC_W-1:0]  acc_i,
    input  logic              round_req_i,
    input  logic              mac_wb_i,
    input  logic              conv_mode_i,
    output logic              out_valid_o,
    output logic [WORD_W-1:0] word_o,
    output logic              ovf_o,
    output logic              sign_o
);

    localparam int UP_LSB   = WORD_W;
    localparam int UP_MSB   = 2*WORD_W - 1;
    localparam int SIGN_BIT = ACC_W - 1;

    logic [WORD_W-1:0] up_word;
    logic [WORD_W-1:0] lo_word;
    logic              round_en;
    logic              inc;
    logic [WORD_W-1:0] sum;
    logic              ovf;
    logic              unused_guard_bits;
    rnd_mode_e         mode;

    assign up_word           = acc_i[UP_MSB:UP_LSB];
    assign lo_word           = acc_i[WORD_W-1:0];
    assign round_en          = round_req_i | mac_wb_i;
    assign mode              = rnd_mode_e'(conv_mode_i);
    assign unused_guard_bits = ^acc_i[SIGN_BIT-1:UP_MSB+1];

    acc_rnd_decide #(.WORD_W(WORD_W)) decide_i (
        .lo_word_i  (lo_word),
        .up_lsb_i   (up_word[0]),
        .round_en_i (round_en),
        .mode_i     (mode),
        .inc_o      (inc)
    );

    acc_rnd_adder #(.WORD_W(WORD_W)) adder_i (
        .up_i  (up_word),
        .inc_i (inc),
        .sum_o (sum),
        .ovf_o (ovf)
    );

    generate
        if (OUT_REG) begin : g_reg
            // Purpose: register the result with a synchronous active-low reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid_o <= 1'b0;
                    word_o      <= '0;
                    ovf_o       <= 1'b0;
                    sign_o      <= 1'b0;
                end else begin
                    out_valid_o <= in_valid_i;
                    word_o      <= sum;
                    ovf_o       <= ovf;
                    sign_o      <= acc_i[SIGN_BIT];
                end
            end

            // R1: truncation passes the upper word through unchanged.
            p_trunc_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid_o && $past(rst_n) && !$past(round_req_i) && !$past(mac_wb_i))
                |-> (word_o == $past(acc_i[UP_MSB:UP_LSB])));

            // R4: a half-to-even tie with an even upper word leaves it alone.
            p_even_tie_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid_o && $past(rst_n) && $past(round_en) && $past(conv_mode_i)
                 && $past(lo_word) == {1'b1, {(WORD_W-1){1'b0}}} && !$past(acc_i[UP_LSB]))
                |-> (word_o == $past(acc_i[UP_MSB:UP_LSB])));

            // R5: a multiply-accumulate writeback with the low word at or above half rounds up.
            p_mac_rounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid_o && $past(rst_n) && $past(mac_wb_i) && !$past(conv_mode_i)
                 && $past(acc_i[WORD_W-1]))
                |-> (word_o == $past(acc_i[UP_MSB:UP_LSB]) + 1'b1));

            // R6: the overflow flag implies the most negative word.
            p_ovf_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
                ovf_o |-> (word_o == {1'b1, {(WORD_W-1){1'b0}}}));

            // R7: the sign follows the accumulator sign of the same operation.
            p_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid_o && $past(rst_n)) |-> (sign_o == $past(acc_i[SIGN_BIT])));

            // R8: the valid output follows the valid input by one cycle.
            p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (out_valid_o == $past(in_valid_i)));
        end else begin : g_comb
            // Purpose: drive the outputs directly from the rounding core.
            always_comb begin
                out_valid_o = in_valid_i;
                word_o      = sum;
                ovf_o       = ovf;
                sign_o      = acc_i[SIGN_BIT];
            end
        end
    endgenerate

endmodule

// File: tb/acc_store_rounder_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected results into a queue, and
// the monitor pops one result for each valid output and compares it.
module acc_store_rounder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [39:0] acc = '0;
    logic        rnd_req = 1'b0;
    logic        mac_wb = 1'b0;
    logic        conv = 1'b0;
    logic        out_valid;
    logic [15:0] word;
    logic        ovf;
    logic        sign;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] q_word[$];
    logic        q_ovf[$];
    logic        q_sign[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    acc_store_rounder dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .acc_i       (acc),
        .round_req_i (rnd_req),
        .mac_wb_i    (mac_wb),
        .conv_mode_i (conv),
        .out_valid_o (out_valid),
        .word_o      (word),
        .ovf_o       (ovf),
        .sign_o      (sign)
    );

    // Expected behaviour, built from the requirements.
    task automatic model(input logic [39:0] a, input logic r, input logic m, input logic c,
                         output logic [15:0] w, output logic o);
        logic [15:0] up;
        logic [15:0] lo;
        logic        inc;
        up  = a[31:16];
        lo  = a[15:0];
        inc = 1'b0;
        if (r || m) begin
            if (c && lo == 16'h8000) inc = a[16];
            else                     inc = lo[15];
        end
        w = up + {15'd0, inc};
        o = inc && (up == 16'h7FFF);
    endtask

    task automatic drive(input logic [39:0] a, input logic r, input logic m, input logic c,
                         input string tag);
        logic [15:0] w;
        logic        o;
        @(negedge clk);
        acc = a; rnd_req = r; mac_wb = m; conv = c; in_valid = 1'b1;
        model(a, r, m, c, w, o);
        q_word.push_back(w);
        q_ovf.push_back(o);
        q_sign.push_back(a[39]);
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        acc = 40'hFF_FFFF_FFFF;
    endtask

    // Monitor: pop and compare one result for each valid output.
    always @(posedge clk) begin
        #1;
        if (rst_n && out_valid) begin
            checks++;
            if (q_word.size() == 0) begin
                errors++;
                $display("FAIL R8: unexpected out_valid, actual 1 expected 0");
            end else begin
                logic [15:0] ew;
                logic        eo;
                logic        es;
                string       t;
                ew = q_word.pop_front();
                eo = q_ovf.pop_front();
                es = q_sign.pop_front();
                t  = q_tag.pop_front();
                if (word !== ew || ovf !== eo || sign !== es) begin
                    errors++;
                    $display("FAIL %s: actual word=%h ovf=%b sign=%b expected word=%h ovf=%b sign=%b",
                             t, word, ovf, sign, ew, eo, es);
                end
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8: reset state.
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || word !== 16'h0 || ovf !== 1'b0 || sign !== 1'b0) begin
            errors++;
            $display("FAIL R8: reset actual v=%b w=%h o=%b s=%b expected 0 0000 0 0",
                     out_valid, word, ovf, sign);
        end
        rst_n = 1'b1;

        // R1: truncation discards the low word.
        drive(40'h00_1234_FFFF, 1'b0, 1'b0, 1'b0, "R1");
        drive(40'h00_7FFF_8000, 1'b0, 1'b0, 1'b1, "R1");
        drive(40'hFF_FFFF_C000, 1'b0, 1'b0, 1'b0, "R1");

        // R2, R3, R4: low words around one half, bit 16 clear and set, both modes.
        for (int md = 0; md < 2; md++) begin
            for (int b16 = 0; b16 < 2; b16++) begin
                logic [15:0] up;
                up = b16 ? 16'h1235 : 16'h1234;
                drive({8'h00, up, 16'h7FFF}, 1'b1, 1'b0, md[0], md ? "R3" : "R2");
                drive({8'h00, up, 16'h8000}, 1'b1, 1'b0, md[0], md ? "R4" : "R2");
                drive({8'h00, up, 16'h8001}, 1'b1, 1'b0, md[0], md ? "R3" : "R2");
            end
        end

        // R5: multiply-accumulate writeback rounds without the round request.
        drive(40'h00_0100_8000, 1'b0, 1'b1, 1'b0, "R5");
        drive(40'h00_0101_8000, 1'b0, 1'b1, 1'b1, "R5");
        drive(40'h00_0102_8000, 1'b0, 1'b1, 1'b1, "R5");

        // R6 with R4: a tie and a wrap in the same operation.
        drive(40'h00_7FFF_8000, 1'b1, 1'b0, 1'b1, "R6");
        drive(40'h00_7FFE_8000, 1'b1, 1'b0, 1'b1, "R6");
        drive(40'h00_7FFF_FFFF, 1'b0, 1'b1, 1'b0, "R6");
        drive(40'hFF_FFFF_8000, 1'b1, 1'b0, 1'b0, "R6");

        // R7: the sign bit passes through.
        drive(40'h80_0000_0000, 1'b0, 1'b0, 1'b0, "R7");
        drive(40'h7F_FFFF_0000, 1'b1, 1'b0, 1'b0, "R7");

        // R8: a bubble clears out_valid.
        idle();
        @(posedge clk); #1;
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R8: bubble actual v=%b expected 0", out_valid);
        end

        // Mixed sweep over every control combination.
        for (int i = 0; i < 200; i++) begin
            logic [39:0] a;
            a = {$urandom(), $urandom()};
            if (i % 4 == 0) a[15:0] = 16'h8000;
            drive(a, 1'($urandom()), 1'($urandom()), 1'($urandom()), "R2");
        end
        idle();
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (q_word.size() != 0) begin
            errors++;
            $display("FAIL R8: pending results actual %0d expected 0", q_word.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule